// File: doc/BRIEF.md
# SIMT Divergence Lane-Mask Unit

This block tracks which lanes of a 32-lane SIMT warp are enabled while the warp walks through structured if/then/else control flow. All enabled lanes run the same instruction, so a divergent branch is handled by running the then path and then the else path, one after the other, each under its own lane mask. The total time of a divergent branch is therefore the time of the then path plus the time of the else path.

On an if, the unit takes one condition bit per lane and turns off every lane whose bit is false. On the matching else, it enables the lanes of the enclosing mask that did not take the then path. On the endif it restores the mask that was in force before the if. Nested branches are held on a mask stack eight levels deep. A skip flag goes high whenever the current path has no enabled lanes, so the issue logic can jump over that path. Misuse is reported as a one-cycle error pulse with a code, and the mask and the stack stay as they were. Instruction execution and branch target computation are outside this block.

Top module: `simt_lane_mask`

## Requirements
- R1: After synchronous reset the mask output is all ones (0xFFFFFFFF), skip_o is 0, err_o is 0 and err_code_o is 0.
- R2: An if (op_i = 1) that does not overflow makes the mask, from the next cycle, equal to the previous mask AND cond_i. Lanes that were off stay off.
- R3: An else (op_i = 2) makes the mask equal to the enclosing mask (the mask before the matching if) AND NOT the condition of that if.
- R4: An endif (op_i = 3) restores the mask that was in force just before the matching if.
- R5: Branches nest to a depth of 8. Every level restores its own enclosing mask, and after eight ifs and eight endifs the mask is all ones again.
- R6: skip_o is 1 exactly when the current mask is all zeros.
- R7: An if issued while 8 levels are open raises err_o for one cycle with err_code_o = 1. The mask and the stack are left unchanged.
- R8: An else with no open if, or a second else at the same level, raises err_o with err_code_o = 2. The mask is left unchanged.
- R9: An endif with no open if raises err_o with err_code_o = 3. The mask is left unchanged.
- R10: op_i = 0 is a no-op. cond_i is ignored and the mask holds. err_o returns to 0 on the cycle after an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 2 | Control op: 0 none, 1 if, 2 else, 3 endif |
| cond_i | input | 32 | Per-lane branch condition, sampled on an if |
| mask_o | output | 32 | Current active-lane mask |
| skip_o | output | 1 | Current path has no active lanes |
| err_o | output | 1 | One-cycle error pulse |
| err_code_o | output | 2 | Error kind: 1 overflow, 2 orphan else, 3 orphan endif |

## Verification
The bench drives nested branches whose conditions overlap only in part. A unit that computed the else mask as a plain inversion of the condition would wake lanes that were off before the if, and the inner else of the nested case exposes it. Filling all eight levels and then issuing one more if catches a stack that wraps or corrupts its top entry: the mask would change and the long unwind would not return to all ones. Orphan else, a repeated else and an orphan endif at depth zero check that a misused op reports the right code and leaves the mask alone. An all-false condition checks that skip follows the mask into and out of an empty path.

// File: rtl/simt_mask_pkg.sv
package simt_mask_pkg;

    parameter int LANES       = 32;
    parameter int STACK_DEPTH = 8;

    localparam int SP_W = $clog2(STACK_DEPTH + 1);

    typedef logic [LANES-1:0] lane_mask_t;
    typedef logic [SP_W-1:0]  stack_ptr_t;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_IF    = 2'd1,
        OP_ELSE  = 2'd2,
        OP_ENDIF = 2'd3
    } ctl_op_e;

    typedef enum logic [1:0] {
        ERR_NONE         = 2'd0,
        ERR_OVERFLOW     = 2'd1,
        ERR_ORPHAN_ELSE  = 2'd2,
        ERR_ORPHAN_ENDIF = 2'd3
    } err_kind_e;

    // One nesting level: mask before the if, lanes that took the then path,
    // and whether the else path has already been entered.
    typedef struct packed {
        lane_mask_t outer;
        lane_mask_t taken;
        logic       in_else;
    } level_t;

    function automatic lane_mask_t fn_then_mask(lane_mask_t cur, lane_mask_t cond);
        return cur & cond;
    endfunction

    function automatic lane_mask_t fn_else_mask(lane_mask_t outer, lane_mask_t taken);
        return outer & ~taken;
    endfunction

endpackage

// File: rtl/simt_mask_ctrl.sv
module simt_mask_ctrl
    import simt_mask_pkg::*;
(
    input  ctl_op_e    op,
    input  logic       full,
    input  logic       empty,
    input  logic       top_in_else,
    output logic       push,
    output logic       pop,
    output logic       mark_else,
    output err_kind_e  err_kind
);

    always_comb begin
        push      = 1'b0;
        pop       = 1'b0;
        mark_else = 1'b0;
        err_kind  = ERR_NONE;
        unique case (op)
            OP_IF: begin
                if (full) err_kind = ERR_OVERFLOW;
                else      push     = 1'b1;
            end
            OP_ELSE: begin
                if (empty || top_in_else) err_kind  = ERR_ORPHAN_ELSE;
                else                      mark_else = 1'b1;
            end
            OP_ENDIF: begin
                if (empty) err_kind = ERR_ORPHAN_ENDIF;
                else       pop      = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
    import simt_mask_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  logic       pop,
    input  logic       mark_else,
    input  level_t     push_level,
    output level_t     top_level,
    output stack_ptr_t count,
    output logic       full,
    output logic       empty
);

    level_t     slot_q [STACK_DEPTH];
    stack_ptr_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            for (int i = 0; i < STACK_DEPTH; i++) slot_q[i] <= '0;
        end else begin
            for (int i = 0; i < STACK_DEPTH; i++) begin
                if (push && cnt_q == stack_ptr_t'(i))
                    slot_q[i] <= push_level;
                else if (mark_else && cnt_q == stack_ptr_t'(i + 1))
                    slot_q[i].in_else <= 1'b1;
            end
            if (push)     cnt_q <= cnt_q + 1'b1;
            else if (pop) cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        top_level = '0;
        for (int i = 0; i < STACK_DEPTH; i++)
            if (cnt_q == stack_ptr_t'(i + 1)) top_level = slot_q[i];
    end

    assign count = cnt_q;
    assign full  = (cnt_q == stack_ptr_t'(STACK_DEPTH));
    assign empty = (cnt_q == '0);

endmodule

// File: rtl/simt_lane_mask.sv
module simt_lane_mask
    import simt_mask_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  op_i,
    input  logic [31:0] cond_i,
    output logic [31:0] mask_o,
    output logic        skip_o,
    output logic        err_o,
    output logic [1:0]  err_code_o
);

    ctl_op_e    op;
    lane_mask_t cur_q;
    lane_mask_t cur_d;
    logic       push, pop, mark_else;
    logic       stk_full, stk_empty;
    err_kind_e  err_kind;
    err_kind_e  err_q;
    level_t     top_level;
    level_t     new_level;
    stack_ptr_t stk_count;

    assign op = ctl_op_e'(op_i);

    simt_mask_ctrl u_ctrl (
        .op          (op),
        .full        (stk_full),
        .empty       (stk_empty),
        .top_in_else (top_level.in_else),
        .push        (push),
        .pop         (pop),
        .mark_else   (mark_else),
        .err_kind    (err_kind)
    );

    assign new_level = '{outer: cur_q, taken: fn_then_mask(cur_q, cond_i), in_else: 1'b0};

    simt_mask_stack u_stack (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .pop        (pop),
        .mark_else  (mark_else),
        .push_level (new_level),
        .top_level  (top_level),
        .count      (stk_count),
        .full       (stk_full),
        .empty      (stk_empty)
    );

    always_comb begin
        cur_d = cur_q;
        if (push)           cur_d = new_level.taken;
        else if (mark_else) cur_d = fn_else_mask(top_level.outer, top_level.taken);
        else if (pop)       cur_d = top_level.outer;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '1;
            err_q <= ERR_NONE;
        end else begin
            cur_q <= cur_d;
            err_q <= err_kind;
        end
    end

    assign mask_o     = cur_q;
    assign skip_o     = ~|cur_q;
    assign err_o      = (err_q != ERR_NONE);
    assign err_code_o = err_q;

endmodule

// File: rtl/simt_lane_mask_chk.sv
module simt_lane_mask_chk
    import simt_mask_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [1:0]  op_i,
    input logic [31:0] cond_i,
    input logic [31:0] mask_o,
    input logic        skip_o,
    input logic        err_o,
    input logic [1:0]  err_code_o,
    input stack_ptr_t  depth
);

    p_if_narrows_r2: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'd1 && depth < stack_ptr_t'(STACK_DEPTH)) |=> mask_o == $past(mask_o & cond_i));

    p_else_disjoint_r3: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'd2 && depth != '0) |=> ((mask_o & $past(mask_o)) == '0 || err_o));

    p_depth_bound_r5: assert property (@(posedge clk) disable iff (rst)
        depth <= stack_ptr_t'(STACK_DEPTH));

    p_skip_empty_r6: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'd1 && cond_i == '0 && depth < stack_ptr_t'(STACK_DEPTH)) |=> skip_o);

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'd1 && depth == stack_ptr_t'(STACK_DEPTH)) |=> (err_o && err_code_o == 2'd1 && $stable(mask_o)));

    p_orphan_else_r8: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'd2 && depth == '0) |=> (err_o && err_code_o == 2'd2 && $stable(mask_o)));

    p_orphan_endif_r9: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'd3 && depth == '0) |=> (err_o && err_code_o == 2'd3 && $stable(mask_o)));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'd0) |=> ($stable(mask_o) && !err_o));

endmodule

bind simt_lane_mask simt_lane_mask_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .op_i       (op_i),
    .cond_i     (cond_i),
    .mask_o     (mask_o),
    .skip_o     (skip_o),
    .err_o      (err_o),
    .err_code_o (err_code_o),
    .depth      (stk_count)
);

// File: tb/simt_lane_mask_tb_top.sv
module simt_lane_mask_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  op_i = 2'd0;
    logic [31:0] cond_i = '0;
    logic [31:0] mask_o;
    logic        skip_o;
    logic        err_o;
    logic [1:0]  err_code_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    simt_lane_mask dut_i (
        .clk(clk), .rst(rst), .op_i(op_i), .cond_i(cond_i),
        .mask_o(mask_o), .skip_o(skip_o), .err_o(err_o), .err_code_o(err_code_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Drive one op for one clock edge, return at the following negedge.
    task automatic apply(input logic [1:0] op, input logic [31:0] cond);
        @(negedge clk);
        op_i   = op;
        cond_i = cond;
        @(negedge clk);
        op_i   = 2'd0;
        cond_i = 32'hDEAD_BEEF;
    endtask

    task automatic t_reset();
        check("R1 mask", mask_o, 32'hFFFF_FFFF);
        check("R1 skip", {31'd0, skip_o}, 32'd0);
        check("R1 err", {31'd0, err_o}, 32'd0);
        check("R1 code", {30'd0, err_code_o}, 32'd0);
    endtask

    task automatic t_idle();
        apply(2'd0, 32'h1234_5678);
        check("R10 mask hold", mask_o, 32'hFFFF_FFFF);
        check("R10 no err", {31'd0, err_o}, 32'd0);
    endtask

    task automatic t_basic();
        apply(2'd1, 32'h0000_FFFF);
        check("R2 then mask", mask_o, 32'h0000_FFFF);
        apply(2'd2, 32'h0);
        check("R3 else mask", mask_o, 32'hFFFF_0000);
        apply(2'd3, 32'h0);
        check("R4 endif restore", mask_o, 32'hFFFF_FFFF);
    endtask

    task automatic t_nested();
        apply(2'd1, 32'h00FF_00FF);
        check("R5 outer then", mask_o, 32'h00FF_00FF);
        apply(2'd1, 32'h0F0F_0F0F);
        check("R2 inner then", mask_o, 32'h000F_000F);
        apply(2'd2, 32'h0);
        check("R3 inner else within enclosing", mask_o, 32'h00F0_00F0);
        apply(2'd3, 32'h0);
        check("R5 inner endif", mask_o, 32'h00FF_00FF);
        apply(2'd2, 32'h0);
        check("R3 outer else", mask_o, 32'hFF00_FF00);
        apply(2'd3, 32'h0);
        check("R5 outer endif", mask_o, 32'hFFFF_FFFF);
    endtask

    task automatic t_skip();
        apply(2'd1, 32'h0);
        check("R6 empty then mask", mask_o, 32'h0);
        check("R6 skip set", {31'd0, skip_o}, 32'd1);
        apply(2'd2, 32'h0);
        check("R6 else mask", mask_o, 32'hFFFF_FFFF);
        check("R6 skip clear", {31'd0, skip_o}, 32'd0);
        apply(2'd3, 32'h0);
    endtask

    task automatic t_overflow();
        logic [31:0] exp_m;
        exp_m = 32'hFFFF_FFFF;
        for (int i = 0; i < 8; i++) begin
            apply(2'd1, ~(32'h1 << i));
            exp_m = exp_m & ~(32'h1 << i);
        end
        check("R5 depth 8 mask", mask_o, exp_m);
        apply(2'd1, 32'h0);
        check("R7 overflow err", {31'd0, err_o}, 32'd1);
        check("R7 overflow code", {30'd0, err_code_o}, 32'd1);
        check("R7 mask unchanged", mask_o, exp_m);
        apply(2'd3, 32'h0);
        check("R7 top level intact", mask_o, exp_m | 32'h80);
        check("R10 err cleared", {31'd0, err_o}, 32'd0);
        for (int i = 0; i < 7; i++) apply(2'd3, 32'h0);
        check("R5 full unwind", mask_o, 32'hFFFF_FFFF);
    endtask

    task automatic t_orphan_else();
        apply(2'd2, 32'h0);
        check("R8 orphan else err", {31'd0, err_o}, 32'd1);
        check("R8 orphan else code", {30'd0, err_code_o}, 32'd2);
        check("R8 mask unchanged", mask_o, 32'hFFFF_FFFF);
        apply(2'd1, 32'hAAAA_AAAA);
        apply(2'd2, 32'h0);
        check("R3 else mask", mask_o, 32'h5555_5555);
        apply(2'd2, 32'h0);
        check("R8 second else code", {30'd0, err_code_o}, 32'd2);
        check("R8 second else mask", mask_o, 32'h5555_5555);
        apply(2'd3, 32'h0);
        check("R4 restore after repeat else", mask_o, 32'hFFFF_FFFF);
    endtask

    task automatic t_orphan_endif();
        apply(2'd3, 32'h0);
        check("R9 orphan endif err", {31'd0, err_o}, 32'd1);
        check("R9 orphan endif code", {30'd0, err_code_o}, 32'd3);
        check("R9 mask unchanged", mask_o, 32'hFFFF_FFFF);
        apply(2'd0, 32'h0);
        check("R10 err pulse ends", {31'd0, err_o}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle();
        t_basic();
        t_nested();
        t_skip();
        t_overflow();
        t_orphan_else();
        t_orphan_endif();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule